// File: doc/BRIEF.md
# Shared Message Queue Bank

The block holds a bank of hardware message queues that several processors share over a 32-bit memory-mapped bus. Every queue has an address window of thirty-two word registers, and sixteen of them carry the message payload. A producer writes payload words in any order. Its write to the last payload register completes the message and commits it into the queue. A consumer reads payload words from the head message, and its read of the last payload register removes that message.

A second address region holds one state register per queue. Each state register reports the number of pending messages and a sticky flag that records a dropped commit. Every queue drives a receive interrupt that stays high while the queue holds at least one message.

Each queue runs a three-state controller: `Q_EMPTY`, `Q_PENDING` and `Q_FULL`. The *push* transition leaves `Q_EMPTY` for `Q_PENDING`, stays in `Q_PENDING`, or moves from `Q_PENDING` to `Q_FULL` when the last free slot fills. The *pop* transition moves from `Q_FULL` to `Q_PENDING`, stays in `Q_PENDING`, or returns from `Q_PENDING` to `Q_EMPTY` when the last message leaves. The *drop* event is a commit while in `Q_FULL`: the state does not change and the overflow flag is set.

Top module: `msg_queue_bank`

## Requirements
- R1: Bus address bit 20 selects the region. When bit 20 is 0, the access goes to the data window. Bits 19:16 form the proxy field, bits 15:7 select the queue and bits 6:2 select the register. Payload registers are 16 to 31, and payload word w sits at register 16+w. When bit 20 is 1, the access goes to the state register of queue q at byte offset 4*q.
- R2: A full write to register 31 commits a message. Payload words 0 to 14 come from the staged writes to registers 16 to 30, and word 15 is the data written to register 31. A word that was not written since the last commit reads as zero. Every commit clears the staging buffer.
- R3: A queue holds up to DEPTH messages (8 by default) and returns them in commit order.
- R4: A full read of registers 16 to 30 returns the matching word of the head message and leaves the queue unchanged. A full read of register 31 returns word 15 and removes the head message.
- R5: Read data appears on bus_rdata with bus_rvalid high in the cycle after the read request.
- R6: The state register holds the pending count in bits 23:12 and the overflow flag in bit 0. All other bits read as zero.
- R7: rx_irq[q] is high exactly when queue q holds at least one message.
- R8: A commit to a full queue is dropped and leaves the count unchanged. It sets the overflow flag. A full write to the state register with bit 0 set clears the flag. A write with bit 0 clear leaves the flag as it is.
- R9: A data-window read of an empty queue returns zero, leaves the count at zero and keeps the interrupt low.
- R10: An access with bus_be other than 4'hF has no effect. A sub-word write neither stages nor commits nor clears. A sub-word read returns zero and does not pop.
- R11: The following accesses are ignored and read as zero: registers 0 to 15, a nonzero proxy field, and a queue index at or beyond NUM_QUEUES.
- R12: Queues are independent. An access to one queue never changes the contents, count or interrupt of another queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables; only 4'hF performs an access |
| bus_addr | input | 21 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | High in the cycle that bus_rdata answers a read |
| rx_irq | output | NUM_QUEUES | Per-queue pending-message interrupt |

## Verification
The bench targets four corner cases. The first is a commit into a full queue. A design that gets this wrong overwrites the oldest message or wraps the count to zero, and the interrupt drops. The second is a short message whose middle words were never written. A faulty design carries stale staging data from the previous message into it. The third is a pop on an empty queue. A faulty design underflows the counter and raises the interrupt. The fourth is a sub-word or out-of-range access. A faulty design commits or pops on a partial write, or answers a read at a non-payload register or a foreign proxy with queue data. Randomly mixed traffic across all queues also exposes any cross-talk between them, and any loss of the commit order.

// File: rtl/mqb_pkg.sv
package mqb_pkg;
    // data-window layout
    localparam int WIN_WORDS   = 16;   // payload words per message
    localparam int REGION_BIT  = 20;   // 1 = state region
    localparam int PROXY_LSB   = 16;
    localparam int QSEL_LSB    = 7;
    localparam int QSEL_W      = 9;
    localparam int CNT_LSB     = 12;   // count field 23:12
    localparam int CNT_FIELD_W = 12;

    typedef enum logic [1:0] {
        Q_EMPTY,
        Q_PENDING,
        Q_FULL
    } qstate_e;

    typedef struct packed {
        logic              data_hit;   // full access to a payload register
        logic              state_hit;  // full access to a state register
        logic [QSEL_W-1:0] qidx;
        logic [3:0]        widx;       // payload word 0..15
        logic              last;       // word 15: commit / pop
    } access_t;
endpackage

// File: rtl/mqb_decode.sv
module mqb_decode
    import mqb_pkg::*;
#(
    parameter int NUM_QUEUES = 4
) (
    input  logic        sel,
    input  logic [3:0]  be,
    input  logic [20:0] addr,
    output access_t     acc
);
    logic full_word;
    logic in_state;
    logic data_ok;
    logic state_ok;

    always_comb begin
        full_word = sel && (be == 4'hF) && (addr[1:0] == 2'b00);
        in_state  = addr[REGION_BIT];
        data_ok   = !in_state
                    && (addr[19:PROXY_LSB] == 4'd0)
                    && (int'(addr[15:QSEL_LSB]) < NUM_QUEUES)
                    && addr[6];
        state_ok  = in_state && (int'(addr[19:2]) < NUM_QUEUES);

        acc.data_hit  = full_word && data_ok;
        acc.state_hit = full_word && state_ok;
        acc.qidx      = in_state ? addr[2 +: QSEL_W] : addr[QSEL_LSB +: QSEL_W];
        acc.widx      = addr[5:2];
        acc.last      = (addr[5:2] == 4'hF);
    end
endmodule

// File: rtl/mqb_queue.sv
module mqb_queue
    import mqb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_word,
    input  logic             rd_word,
    input  logic [3:0]       widx,
    input  logic [31:0]      wdata,
    input  logic             ovf_clr,
    output logic [31:0]      head_word,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             irq
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [31:0]      stage [WIN_WORDS];
    logic [31:0]      mem   [DEPTH][WIN_WORDS];
    logic [PTR_W-1:0] wptr, rptr;
    qstate_e          state_q, state_d;
    logic             commit, push, pop, full, has_msg;

    assign commit = wr_word && (widx == 4'hF);
    assign push   = commit && !full;
    assign pop    = rd_word && (widx == 4'hF) && has_msg;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY:   if (push) state_d = (DEPTH == 1) ? Q_FULL : Q_PENDING;
            Q_PENDING: begin
                if (push && (int'(count) == DEPTH - 1)) state_d = Q_FULL;
                else if (pop && (count == CNT_W'(1)))   state_d = Q_EMPTY;
            end
            Q_FULL:    if (pop) state_d = (DEPTH == 1) ? Q_EMPTY : Q_PENDING;
            default:   state_d = Q_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_d;
    end

    // state outputs
    always_comb begin
        has_msg = 1'b0;
        full    = 1'b0;
        unique case (state_q)
            Q_EMPTY:   ;
            Q_PENDING: has_msg = 1'b1;
            Q_FULL:    begin has_msg = 1'b1; full = 1'b1; end
            default:   ;
        endcase
        irq = has_msg;
    end

    // counters and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (push) begin
                wptr  <= (int'(wptr) == DEPTH - 1) ? '0 : wptr + 1'b1;
                count <= count + 1'b1;
            end
            if (pop) begin
                rptr  <= (int'(rptr) == DEPTH - 1) ? '0 : rptr + 1'b1;
                count <= count - 1'b1;
            end
            if (commit && full) ovf <= 1'b1;
            else if (ovf_clr)   ovf <= 1'b0;
        end
    end

    // staging buffer
    always_ff @(posedge clk) begin
        if (!rst_n || commit) begin
            for (int w = 0; w < WIN_WORDS; w++) stage[w] <= '0;
        end else if (wr_word) begin
            stage[widx] <= wdata;
        end
    end

    // message storage
    always_ff @(posedge clk) begin
        if (push) begin
            for (int w = 0; w < WIN_WORDS - 1; w++) mem[wptr][w] <= stage[w];
            mem[wptr][WIN_WORDS-1] <= wdata;
        end
    end

    assign head_word = has_msg ? mem[rptr][widx] : 32'd0;
endmodule

// File: rtl/msg_queue_bank.sv
module msg_queue_bank
    import mqb_pkg::*;
#(
    parameter int NUM_QUEUES = 4,
    parameter int DEPTH      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [3:0]            bus_be,
    input  logic [20:0]           bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  bus_rvalid,
    output logic [NUM_QUEUES-1:0] rx_irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int QW    = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1;

    access_t                          acc;
    logic [NUM_QUEUES-1:0][31:0]      q_head;
    logic [NUM_QUEUES-1:0][CNT_W-1:0] q_cnt;
    logic [NUM_QUEUES-1:0]            q_ovf;
    logic [QW-1:0]                    qs;
    logic [31:0]                      rd_next;

    mqb_decode #(.NUM_QUEUES(NUM_QUEUES)) u_decode (
        .sel  (bus_sel),
        .be   (bus_be),
        .addr (bus_addr),
        .acc  (acc)
    );

    for (genvar i = 0; i < NUM_QUEUES; i++) begin : g_q
        logic hit_q;
        assign hit_q = (acc.qidx == QSEL_W'(i));
        mqb_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_word   (acc.data_hit && bus_wr && hit_q),
            .rd_word   (acc.data_hit && !bus_wr && hit_q),
            .widx      (acc.widx),
            .wdata     (bus_wdata),
            .ovf_clr   (acc.state_hit && bus_wr && hit_q && bus_wdata[0]),
            .head_word (q_head[i]),
            .count     (q_cnt[i]),
            .ovf       (q_ovf[i]),
            .irq       (rx_irq[i])
        );
    end

    assign qs = acc.qidx[QW-1:0];

    always_comb begin
        rd_next = 32'd0;
        if (acc.data_hit) begin
            rd_next = q_head[qs];
        end else if (acc.state_hit) begin
            rd_next[CNT_LSB +: CNT_FIELD_W] = CNT_FIELD_W'(q_cnt[qs]);
            rd_next[0]                      = q_ovf[qs];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_sel && !bus_wr;
            if (bus_sel && !bus_wr) bus_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/mqb_checker.sv
module mqb_checker #(
    parameter int NUM_QUEUES = 4,
    parameter int DEPTH      = 8,
    parameter int CNT_W      = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            bus_sel,
    input logic                            bus_wr,
    input logic [3:0]                      bus_be,
    input logic [31:0]                     bus_rdata,
    input logic                            bus_rvalid,
    input logic [NUM_QUEUES-1:0]           rx_irq,
    input logic [NUM_QUEUES-1:0][CNT_W-1:0] q_cnt
);
    a_r5_rvalid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    a_r5_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);

    a_r10_subword_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_be != 4'hF) |=> (bus_rdata == 32'd0));

    a_r12_one_irq_change: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rx_irq ^ $past(rx_irq)) <= 1);

    a_r2_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> ((rx_irq & ~$past(rx_irq)) == '0));

    a_r4_fall_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> ((~rx_irq & $past(rx_irq)) == '0));

    for (genvar i = 0; i < NUM_QUEUES; i++) begin : g_chk
        a_r7_irq_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
            rx_irq[i] == (q_cnt[i] != '0));
        a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
            int'(q_cnt[i]) <= DEPTH);
    end
endmodule

bind msg_queue_bank mqb_checker #(
    .NUM_QUEUES (NUM_QUEUES),
    .DEPTH      (DEPTH),
    .CNT_W      (CNT_W)
) u_mqb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_be     (bus_be),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .rx_irq     (rx_irq),
    .q_cnt      (q_cnt)
);

// File: tb/test_msg_queue_bank.sv
module test_msg_queue_bank;
    localparam int NQ = 4;
    localparam int DP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = 4'hF;
    logic [20:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [NQ-1:0] rx_irq;

    always #2 clk = ~clk;   // 250 MHz

    msg_queue_bank #(.NUM_QUEUES(NQ), .DEPTH(DP)) i_msg_queue_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .rx_irq(rx_irq)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model
    logic [31:0] m_fifo  [NQ][DP][16];
    logic [31:0] m_stage [NQ][16];
    int          m_cnt   [NQ];
    int          m_rd    [NQ];
    int          m_wr    [NQ];
    logic        m_ovf   [NQ];

    function automatic logic [20:0] daddr(int q, int reg_n, int proxy = 0);
        return 21'((proxy << 16) | (q << 7) | (reg_n << 2));
    endfunction

    function automatic logic [20:0] saddr(int q);
        return 21'((1 << 20) | (q << 2));
    endfunction

    function automatic logic [31:0] exp_state(int q);
        return (32'(m_cnt[q]) << 12) | 32'(m_ovf[q]);
    endfunction

    function automatic logic [NQ-1:0] exp_irq();
        logic [NQ-1:0] v;
        for (int q = 0; q < NQ; q++) v[q] = (m_cnt[q] != 0);
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int q = 0; q < NQ; q++) begin
            m_cnt[q] = 0; m_rd[q] = 0; m_wr[q] = 0; m_ovf[q] = 1'b0;
            for (int w = 0; w < 16; w++) m_stage[q][w] = '0;
        end
    endtask

    task automatic bus_write(input logic [20:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'hF;
    endtask

    task automatic bus_read(input logic [20:0] a, input logic [3:0] be,
                            output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
        @(negedge clk);
        d = bus_rdata; v = bus_rvalid;
        bus_sel = 1'b0; bus_be = 4'hF;
    endtask

    // payload write to queue q, word w (register 16+w)
    task automatic qwrite(int q, int w, logic [31:0] d, logic [3:0] be = 4'hF);
        bus_write(daddr(q, 16 + w), d, be);
        if (be == 4'hF) begin
            if (w == 15) begin
                if (m_cnt[q] < DP) begin
                    for (int k = 0; k < 15; k++) m_fifo[q][m_wr[q]][k] = m_stage[q][k];
                    m_fifo[q][m_wr[q]][15] = d;
                    m_wr[q] = (m_wr[q] + 1) % DP;
                    m_cnt[q]++;
                end else begin
                    m_ovf[q] = 1'b1;
                end
                for (int k = 0; k < 16; k++) m_stage[q][k] = '0;
            end else begin
                m_stage[q][w] = d;
            end
        end
    endtask

    task automatic qread(string req, int q, int w, logic [3:0] be = 4'hF);
        logic [31:0] e, d;
        logic v;
        e = '0;
        if (be == 4'hF && m_cnt[q] != 0) begin
            e = m_fifo[q][m_rd[q]][w];
            if (w == 15) begin
                m_rd[q] = (m_rd[q] + 1) % DP;
                m_cnt[q]--;
            end
        end
        bus_read(daddr(q, 16 + w), be, d, v);
        chk(req, d, e);
        chk("R5 rvalid", 32'(v), 32'd1);
    endtask

    task automatic sread(string req, int q);
        logic [31:0] d;
        logic v;
        bus_read(saddr(q), 4'hF, d, v);
        chk(req, d, exp_state(q));
    endtask

    task automatic swrite(int q, logic [31:0] d, logic [3:0] be = 4'hF);
        bus_write(saddr(q), d, be);
        if (be == 4'hF && d[0]) m_ovf[q] = 1'b0;
    endtask

    task automatic chk_irq(string req);
        chk(req, 32'(rx_irq), 32'(exp_irq()));
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic v;
        void'($urandom(32'h1C0FFEE));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R7 reset irq", 32'(rx_irq), 32'd0);
        chk("R5 reset rvalid", 32'(bus_rvalid), 32'd0);
        for (int q = 0; q < NQ; q++) sread("R6 reset state", q);

        // R2: short message, middle words skipped
        qwrite(0, 0, 32'hA0A0_0001);
        qwrite(0, 4, 32'hA0A0_0005);
        chk_irq("R2 no commit before word 15");
        qwrite(0, 15, 32'hA0A0_00FF);
        chk_irq("R7 irq after commit");
        sread("R6 count one", 0);
        for (int w = 0; w < 16; w++) qread("R2 R4 payload word", 0, w);
        chk_irq("R7 irq low after last pop");

        // R2: staging cleared after commit
        qwrite(0, 3, 32'h1234_5678);
        qwrite(0, 15, 32'h0000_0015);
        qwrite(0, 15, 32'h0000_0016);
        qread("R2 first msg word3", 0, 3);
        qread("R2 first msg pop", 0, 15);
        qread("R2 stage cleared word3", 0, 3);
        qread("R2 second msg pop", 0, 15);

        // R3 / R8: fill queue 1, overflow
        for (int m = 0; m < DP; m++) begin
            qwrite(1, 0, 32'hB000_0000 + m);
            qwrite(1, 15, 32'hB0F0_0000 + m);
        end
        sread("R3 full count", 1);
        qwrite(1, 0, 32'hDEAD_0000);
        qwrite(1, 15, 32'hDEAD_FFFF);
        sread("R8 overflow set, count kept", 1);
        chk_irq("R12 only queue 1 pending");
        swrite(1, 32'h0);
        sread("R8 write zero keeps flag", 1);
        swrite(1, 32'h1, 4'h1);
        sread("R10 subword clear ignored", 1);
        swrite(1, 32'h1);
        sread("R8 write one clears flag", 1);
        for (int m = 0; m < DP; m++) begin
            qread("R3 order word0", 1, 0);
            qread("R3 order pop", 1, 15);
        end
        sread("R3 drained", 1);

        // R9: empty reads
        qread("R9 empty pop returns zero", 2, 15);
        qread("R9 empty word returns zero", 2, 7);
        sread("R9 count stays zero", 2);
        chk_irq("R9 irq stays low");

        // R10: sub-word accesses
        qwrite(3, 15, 32'h5555_5555, 4'h3);
        chk_irq("R10 subword write no commit");
        qwrite(3, 2, 32'hCAFE_0002, 4'hC);
        qwrite(3, 15, 32'h3333_0015);
        qread("R10 subword read no pop", 3, 15, 4'h8);
        sread("R10 count kept", 3);
        qread("R10 subword word not staged", 3, 2);
        qread("R10 pop", 3, 15);

        // R11: ignored addresses
        bus_write(daddr(2, 31, 1), 32'h7777_7777, 4'hF);
        bus_write(daddr(2, 31, 0) | 21'(NQ << 7), 32'h7777_7777, 4'hF);
        bus_write(daddr(2, 5), 32'h7777_7777, 4'hF);
        chk_irq("R11 ignored writes");
        qwrite(2, 15, 32'h2222_2222);
        bus_read(daddr(2, 31, 1), 4'hF, d, v);
        chk("R11 proxy read zero", d, 32'd0);
        bus_read(daddr(2, 15), 4'hF, d, v);
        chk("R11 low register read zero", d, 32'd0);
        bus_read(saddr(NQ), 4'hF, d, v);
        chk("R11 state out of range", d, 32'd0);
        sread("R11 count unchanged", 2);
        qread("R1 R4 pop queue 2", 2, 15);

        // random mixed traffic
        for (int i = 0; i < 1500; i++) begin
            int q, op, w;
            logic [3:0] be;
            q  = $urandom_range(NQ - 1);
            op = $urandom_range(9);
            w  = $urandom_range(14);
            be = ($urandom_range(15) == 0) ? 4'h3 : 4'hF;
            unique case (op)
                0, 1, 2: qwrite(q, w, $urandom(), be);
                3, 4:    qwrite(q, 15, $urandom(), be);
                5:       qread("R4 random word", q, w, be);
                6, 7:    qread("R4 random pop", q, 15, be);
                8:       sread("R6 random state", q);
                default: swrite(q, $urandom(), be);
            endcase
            chk_irq("R7 R12 random irq");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule